// File: doc/BRIEF.md
# Byte-Wide Timing Register Loader

This block fills a bank of 12-bit timing registers from an 8-bit programming bus. A write strobe (`ld`) that runs independently of the system clock marks each transfer. Two control lines classify each transfer: whether the bus carries an address or data, and, for data, whether it fills the lower eight bits or the upper four bits of the selected register. The control lines are taken at the strobe's falling edge. The bus value is taken at its rising edge. Both edges are found in the system clock domain after a two-flop synchronizer.

An address transfer with the upper flag set switches on a sequencing mode. In that mode the selected register index moves forward by one after every upper-nibble write and wraps from the last register to register 0. A whole bank can then be programmed with one address transfer followed by pairs of data transfers. Every register drives a parallel output. A one-cycle strobe marks every data write. An active-high asynchronous clear returns the bank, the index and the mode to their built-in state.

Top module: `treg_loader`

## Requirements
- R1: While `clr` is high, register k holds its default of 16*k (modulo 4096), so register 0 (status) is 0. The index also returns to 0 and sequencing mode turns off.
- R2: `ld_kind` and `ld_upper` take effect only as sampled at the falling edge of `ld`. Changes made while `ld` is low have no effect on the transfer that completes at the next rising edge.
- R3: A data transfer updates the bank and raises `wr_stb` in the same cycle, within three clock cycles after `ld` rises. Neither happens without a rising edge of `ld`.
- R4: With `ld_kind`=0 the transfer is an address: `din[3:0]` becomes the register index. No register changes and `wr_stb` stays low.
- R5: With `ld_kind`=1 and `ld_upper`=0, bits 7:0 of the indexed register become `din[7:0]` and bits 11:8 keep their value.
- R6: With `ld_kind`=1 and `ld_upper`=1, bits 11:8 of the indexed register become `din[3:0]`. `din[7:4]` is ignored and bits 7:0 keep their value.
- R7: An address transfer with `ld_upper`=1 turns sequencing mode on. One with `ld_upper`=0 turns it off.
- R8: In sequencing mode each upper-nibble write advances the index by one, from 15 back to 0. Lower-byte writes do not advance it.
- R9: Outside sequencing mode the index stays unchanged across any number of data writes.
- R10: `wr_stb` is high for exactly one cycle per data write, and the register outputs change only in cycles where `wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| ld | input | 1 | Transfer strobe, asynchronous, idles high |
| ld_kind | input | 1 | 0 = address transfer, 1 = data transfer |
| ld_upper | input | 1 | Data: 0 = bits 7:0, 1 = bits 11:8; address: sequencing enable |
| din | input | 8 | Programming bus |
| regs_flat | output | 192 | Register k at bits 12k+11 : 12k |
| wr_stb | output | 1 | One-cycle pulse per data write |

## Verification
The bench first writes lower and upper halves to one register with sequencing off, using bus values whose upper nibble is nonzero. This separates correct nibble steering from a whole-byte copy and from a stray index step. Plain address transfers followed by repeated writes show that the index holds. A run of paired writes that starts two registers below the end shows the index advancing and wrapping, and an extra lower-byte write shows that only upper writes step it. Transfers whose control lines flip while the strobe is low tell falling-edge capture apart from rising-edge capture. A clear in the middle of the run shows that defaults, index and mode all return.

// File: rtl/treg_pkg.sv
package treg_pkg;
  localparam int unsigned DEF_STEP = 16;

  typedef struct packed {
    logic is_data;
    logic upper;
  } ld_ctrl_t;

  function automatic logic [31:0] reg_default(input int unsigned idx);
    return 32'(idx * DEF_STEP);
  endfunction

  function automatic int unsigned next_index(input int unsigned cur, input int unsigned count);
    return (cur >= count - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/treg_edge_sync.sv
module treg_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) chain <= {(STAGES + 1){IDLE}};
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/treg_addr_ctl.sv
module treg_addr_ctl
  import treg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          addr_evt,
  input  logic          hi_evt,
  input  logic          upper_in,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] addr_o,
  output logic          auto_o
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      addr_o <= '0;
      auto_o <= 1'b0;
    end else if (addr_evt) begin
      addr_o <= bus_addr;
      auto_o <= upper_in;
    end else if (hi_evt && auto_o) begin
      addr_o <= AW'(next_index(32'(addr_o), NUM_REGS));
    end
  end
endmodule

// File: rtl/treg_bank.sv
module treg_bank
  import treg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W = 12,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      lo_evt,
  input  logic                      hi_evt,
  input  logic [AW-1:0]             addr,
  input  logic [BUS_W-1:0]          din,
  output logic [NUM_REGS*REG_W-1:0] regs_o,
  output logic                      stb_o
);
  localparam int unsigned HI_W = REG_W - BUS_W;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] q;
    logic             hit;
    assign hit = (addr == AW'(i));

    always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
        q <= REG_W'(reg_default(i));
      end else if (hit) begin
        if (lo_evt) q[BUS_W-1:0] <= din;
        if (hi_evt) q[REG_W-1:BUS_W] <= din[HI_W-1:0];
      end
    end

    assign regs_o[i*REG_W +: REG_W] = q;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) stb_o <= 1'b0;
    else     stb_o <= lo_evt | hi_evt;
  end
endmodule

// File: rtl/treg_loader.sv
module treg_loader
  import treg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W = 12,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      ld,
  input  logic                      ld_kind,
  input  logic                      ld_upper,
  input  logic [BUS_W-1:0]          din,
  output logic [NUM_REGS*REG_W-1:0] regs_flat,
  output logic                      wr_stb
);
  localparam int unsigned AW = $clog2(NUM_REGS);

  logic     rise_evt, fall_evt;
  logic     addr_evt, lo_evt, hi_evt;
  ld_ctrl_t ctrl_q;
  logic [AW-1:0] addr_q;
  logic     auto_q;

  treg_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .clr(clr), .async_in(ld), .rise_o(rise_evt), .fall_o(fall_evt)
  );

  // control lines are latched on the strobe's falling edge
  always_ff @(posedge clk or posedge clr) begin
    if (clr)           ctrl_q <= '0;
    else if (fall_evt) ctrl_q <= '{is_data: ld_kind, upper: ld_upper};
  end

  assign addr_evt = rise_evt & ~ctrl_q.is_data;
  assign lo_evt   = rise_evt &  ctrl_q.is_data & ~ctrl_q.upper;
  assign hi_evt   = rise_evt &  ctrl_q.is_data &  ctrl_q.upper;

  treg_addr_ctl #(.NUM_REGS(NUM_REGS), .AW(AW)) u_addr (
    .clk(clk), .clr(clr), .addr_evt(addr_evt), .hi_evt(hi_evt),
    .upper_in(ctrl_q.upper), .bus_addr(din[AW-1:0]),
    .addr_o(addr_q), .auto_o(auto_q)
  );

  treg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .BUS_W(BUS_W), .AW(AW)) u_bank (
    .clk(clk), .clr(clr), .lo_evt(lo_evt), .hi_evt(hi_evt),
    .addr(addr_q), .din(din), .regs_o(regs_flat), .stb_o(wr_stb)
  );
endmodule

// File: rtl/treg_loader_chk.sv
module treg_loader_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W = 12,
  parameter int unsigned AW = 4
) (
  input logic                      clk,
  input logic                      clr,
  input logic                      rise_evt,
  input logic                      fall_evt,
  input logic                      addr_evt,
  input logic                      lo_evt,
  input logic                      hi_evt,
  input logic                      upper_cap,
  input logic [AW-1:0]             addr_q,
  input logic                      auto_q,
  input logic                      wr_stb,
  input logic [NUM_REGS*REG_W-1:0] regs_flat
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  p_edges_apart_r3: assert property (@(posedge clk) disable iff (clr)
    $onehot0({rise_evt, fall_evt}));

  p_strobe_cause_r3: assert property (@(posedge clk) disable iff (clr)
    wr_stb |-> $past(lo_evt || hi_evt));

  p_strobe_once_r10: assert property (@(posedge clk) disable iff (clr)
    wr_stb |=> !wr_stb);

  p_quiet_regs_r10: assert property (@(posedge clk) disable iff (clr)
    !wr_stb |-> $stable(regs_flat));

  p_addr_no_strobe_r4: assert property (@(posedge clk) disable iff (clr)
    addr_evt |=> !wr_stb);

  p_mode_set_r7: assert property (@(posedge clk) disable iff (clr)
    addr_evt |=> (auto_q == $past(upper_cap)));

  p_auto_step_r8: assert property (@(posedge clk) disable iff (clr)
    (hi_evt && auto_q && addr_q != LAST) |=> (addr_q == $past(addr_q) + AW'(1)));

  p_auto_wrap_r8: assert property (@(posedge clk) disable iff (clr)
    (hi_evt && auto_q && addr_q == LAST) |=> (addr_q == '0));

  p_index_hold_r9: assert property (@(posedge clk) disable iff (clr)
    (lo_evt || (hi_evt && !auto_q)) |=> $stable(addr_q));
endmodule

bind treg_loader treg_loader_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .AW(AW)) u_chk (
  .clk(clk), .clr(clr), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .addr_evt(addr_evt), .lo_evt(lo_evt), .hi_evt(hi_evt),
  .upper_cap(ctrl_q.upper), .addr_q(addr_q), .auto_q(auto_q),
  .wr_stb(wr_stb), .regs_flat(regs_flat)
);

// File: tb/treg_loader_test.sv
`timescale 1ns/1ps
module treg_loader_test;
  localparam int N = 16;
  localparam int W = 12;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic ld = 1'b1;
  logic ld_kind = 1'b0;
  logic ld_upper = 1'b0;
  logic [7:0] din = '0;
  logic [N*W-1:0] regs_flat;
  logic wr_stb;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [W-1:0] m [N];
  int m_idx = 0;
  bit m_auto = 0;
  logic [N*W-1:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  treg_loader uut (
    .clk(clk), .clr(clr), .ld(ld), .ld_kind(ld_kind), .ld_upper(ld_upper),
    .din(din), .regs_flat(regs_flat), .wr_stb(wr_stb)
  );

  function automatic logic [N*W-1:0] model_flat();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = m[k];
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N; k++) m[k] = W'(k << 4);
    m_idx = 0;
    m_auto = 0;
  endtask

  // monitor: each strobe pops one expected snapshot
  always @(negedge clk) begin
    if (!clr && wr_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected wr_stb, actual regs %h expected no write", regs_flat);
      end else begin
        logic [N*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (regs_flat !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, regs_flat, e);
        end
      end
    end
  end

  // driver: one strobe cycle, optional control flip while ld is low (R2)
  task automatic xfer(input bit kind, input bit upper, input logic [7:0] data,
                      input bit scramble, input string tag);
    @(negedge clk);
    ld_kind = kind; ld_upper = upper;
    @(negedge clk) ld = 1'b0;
    repeat (4) @(negedge clk);
    if (scramble) begin ld_kind = ~kind; ld_upper = ~upper; end
    din = data;
    if (!kind) begin
      m_idx = int'(data[3:0]);
      m_auto = upper;
    end else begin
      if (!upper) m[m_idx][7:0] = data;
      else begin
        m[m_idx][11:8] = data[3:0];
        if (m_auto) m_idx = (m_idx + 1) % N;
      end
      exp_q.push_back(model_flat());
      tag_q.push_back(tag);
    end
    @(negedge clk) ld = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    checks++;
    if (regs_flat !== model_flat() || exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (pending %0d)", tag, regs_flat, model_flat(), exp_q.size());
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_state("R1 defaults under clear");
    @(negedge clk) clr = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1 defaults after clear");

    // R5/R6 nibble steering on register 0, sequencing off
    xfer(1, 0, 8'hA5, 0, "R5 low byte reg0");
    xfer(1, 1, 8'hF3, 0, "R6 upper nibble reg0, din[7:4] ignored");
    xfer(1, 0, 8'h11, 0, "R9 index held, low byte reg0");
    check_state("R9 reg0 after writes");

    // R4 address transfer
    xfer(0, 0, 8'h05, 0, "R4 address 5");
    check_state("R4 no register change");
    xfer(1, 1, 8'hE7, 0, "R6 upper nibble reg5");
    xfer(1, 0, 8'h5C, 0, "R5 low byte reg5");
    xfer(1, 1, 8'h09, 0, "R9 upper again reg5");

    // R2 controls flipped while ld low
    xfer(0, 0, 8'h07, 1, "R2 address kept as address");
    check_state("R2 no write from flipped address");
    xfer(1, 0, 8'h3D, 1, "R2 low byte kept as low");
    xfer(1, 1, 8'hC2, 1, "R2 upper kept as upper");

    // R7/R8 sequencing with wrap
    xfer(0, 1, 8'h0E, 0, "R7 enable sequencing at 14");
    check_state("R7 address write no change");
    xfer(1, 0, 8'h01, 0, "R8 reg14 low");
    xfer(1, 1, 8'h81, 0, "R8 reg14 upper, step");
    xfer(1, 0, 8'h02, 0, "R8 reg15 low");
    xfer(1, 1, 8'h42, 0, "R8 reg15 upper, wrap");
    xfer(1, 0, 8'h03, 0, "R8 reg0 after wrap");
    xfer(1, 1, 8'h03, 0, "R8 reg0 upper, step");
    xfer(1, 0, 8'h44, 0, "R8 reg1 low");
    xfer(1, 0, 8'h55, 0, "R8 low does not step");
    check_state("R8 sequence result");

    // R7 disable
    xfer(0, 0, 8'h03, 0, "R7 disable sequencing");
    xfer(1, 1, 8'h0A, 0, "R9 reg3 upper");
    xfer(1, 1, 8'h0B, 0, "R9 reg3 upper repeat");
    check_state("R9 index held at 3");

    // R1 mid-run clear
    @(negedge clk) clr = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    check_state("R1 clear restores defaults");
    @(negedge clk) clr = 1'b0;
    repeat (2) @(negedge clk);
    xfer(1, 1, 8'h0F, 0, "R1 index back to 0 after clear");
    xfer(1, 1, 8'h06, 0, "R1 sequencing off after clear");
    check_state("R3 final state");

    finish_run();
  end
endmodule